// File: doc/BRIEF.md
# Serial Flash Status Register File

This block holds the three 8-bit status registers of a serial flash device. It sits behind an SPI deserializer. The deserializer hands it whole command bytes on a valid/ready stream and marks the rise of chip select with a one-cycle end pulse. That pulse carries a flag when a byte was left incomplete. The first byte of a command is the opcode. The block recognises these opcodes:
- one read opcode for each status register;
- write enable and write disable;
- a write-status command that carries one, two or three data bytes.

Array operations drive the busy and suspend bits from outside.

The block decides which bits a write may change. It makes the four security lock bits one-time programmable. It applies the length-dependent side effects of a write-status command. A write-status command takes effect only when the end marker arrives after whole bytes and the write-enable latch is set. Read data goes out on a second valid/ready stream that stays valid for the whole read phase. On every beat it shows the live value of the selected register.

Back-pressure: `cmd_ready` is high except during a read phase while `rsp_ready` is low. The consumer of read bytes can therefore hold the deserializer. Each accepted command byte in a read phase pairs with one response beat. `rsp_valid` never depends on `rsp_ready`.

Top module: `sfsr_status_regfile`

## Requirements
- R1: After reset, stat1 reads 0x00 apart from its busy mirror, stat2 reads 0x00 apart from its suspend mirror, and stat3 reads 0x10. Bit 4 of stat3 is the wrap-disable bit, which resets to 1.
- R2: After opcode 0x05, 0x35 or 0x33, the response stream is valid until the end marker and carries stat1, stat2 or stat3 respectively. Every beat shows the current value, with no limit on the number of beats. During the read phase, cmd_ready equals rsp_ready.
- R3: Opcode 0x06 sets the write-enable latch (stat1 bit 1), and opcode 0x04 clears it. Either one takes effect at a whole-byte end marker.
- R4: A write-status command (opcode 0x01) changes nothing while the write-enable latch is 0.
- R5: The first data byte of a write-status command loads stat1 bits 7:2. Bits 1:0 of stat1 and bit 7 of stat2 are never written, and bit 7 of stat3 always reads 0.
- R6: A write-status command that carries exactly one data byte clears stat2 bits 6 (complement), 1 (quad enable) and 0 (protect-1). It leaves the lock bits 5:2 and stat3 unchanged.
- R7: A second data byte loads stat2 bits 6, 1 and 0 and ORs its bits 5:2 into the lock bits, so a lock bit never returns to 0. A third data byte loads stat3 bits 6:0. Data bytes after the third are ignored.
- R8: A write-status command that is applied clears the write-enable latch.
- R9: An end marker flagged as a partial byte discards the command: no register and no latch changes.
- R10: Register contents change only on a cycle that carries the end marker, and the response stream drops in the cycle after the end marker.
- R11: stat1 bit 0 mirrors busy_in and stat2 bit 7 mirrors suspend_in in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte accepted when high together with cmd_valid |
| cmd_byte | input | 8 | Command byte (opcode first) |
| cs_done | input | 1 | One-cycle end-of-command marker (chip select rise) |
| cs_ragged | input | 1 | With cs_done: a partial byte was received |
| rsp_valid | output | 1 | Read data valid (whole read phase) |
| rsp_ready | input | 1 | Read data consumed |
| rsp_byte | output | 8 | Live value of the selected register |
| busy_in | input | 1 | External busy flag |
| suspend_in | input | 1 | External suspend flag |
| stat1 | output | 8 | Status register 1 |
| stat2 | output | 8 | Status register 2 |
| stat3 | output | 8 | Status register 3 |

## Verification
The registers drive the stat outputs directly, so a wrong stored bit shows up at the ports in the cycle after the end marker that wrote it. A lost or stuck write-enable latch shows in stat1 bit 1 at the same time, and again when a later write is applied or dropped. A wrong command state makes rsp_valid and cmd_ready differ from the expected values one cycle after the opcode is accepted. A wrong byte count shows as wrong side effects on stat2 or stat3 at the next end marker.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG = 3;
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [CNT_W-1:0] WR_MAX = CNT_W'(NREG);
  localparam logic [BYTE_W-2:0] CFG_RESET = 7'h10;

  localparam logic [BYTE_W-1:0] OP_RD1 = 8'h05;
  localparam logic [BYTE_W-1:0] OP_RD2 = 8'h35;
  localparam logic [BYTE_W-1:0] OP_RD3 = 8'h33;
  localparam logic [BYTE_W-1:0] OP_WRS = 8'h01;
  localparam logic [BYTE_W-1:0] OP_WEN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WDI = 8'h04;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WEN, ST_WDI, ST_WRS, ST_SKIP
  } cmd_st_e;

  typedef logic [NREG-1:0][BYTE_W-1:0] wr_buf_t;
endpackage

// File: rtl/sfsr_cmd_fsm.sv
module sfsr_cmd_fsm
  import sfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_fire,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              end_mark,
  input  logic              end_ragged,
  output logic              rd_active,
  output logic [1:0]        rd_sel,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              wr_commit,
  output logic [CNT_W-1:0]  wr_len,
  output wr_buf_t           wr_bytes
);
  cmd_st_e st_q, st_d, kind;
  logic [1:0] sel_q, sel_d;
  logic [CNT_W-1:0] cnt_q, n_cnt;
  wr_buf_t buf_q, n_buf;
  logic op_fire, data_fire, whole_end;

  function automatic cmd_st_e classify(input logic [BYTE_W-1:0] op);
    case (op)
      OP_WRS:                 classify = ST_WRS;
      OP_WEN:                 classify = ST_WEN;
      OP_WDI:                 classify = ST_WDI;
      OP_RD1, OP_RD2, OP_RD3: classify = ST_READ;
      default:                classify = ST_SKIP;
    endcase
  endfunction

  always_comb begin
    op_fire   = byte_fire && (st_q == ST_IDLE);
    data_fire = byte_fire && (st_q == ST_WRS) && (cnt_q != WR_MAX);
    n_cnt     = cnt_q + CNT_W'(data_fire);
    n_buf     = buf_q;
    if (data_fire) n_buf[cnt_q[1:0]] = byte_in;
    kind  = op_fire ? classify(byte_in) : st_q;
    sel_d = sel_q;
    if (op_fire) begin
      case (byte_in)
        OP_RD2:  sel_d = 2'd1;
        OP_RD3:  sel_d = 2'd2;
        default: sel_d = 2'd0;
      endcase
    end
    st_d = end_mark ? ST_IDLE : kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sel_q <= '0;
      cnt_q <= '0;
      buf_q <= '0;
    end else begin
      st_q  <= st_d;
      sel_q <= sel_d;
      cnt_q <= end_mark ? '0 : n_cnt;
      buf_q <= n_buf;
    end
  end

  assign whole_end = end_mark && !end_ragged;
  assign wel_set   = whole_end && (kind == ST_WEN);
  assign wel_clr   = whole_end && (kind == ST_WDI);
  assign wr_commit = whole_end && (kind == ST_WRS) && (n_cnt != '0);
  assign wr_len    = n_cnt;
  assign wr_bytes  = n_buf;
  assign rd_active = (st_q == ST_READ);
  assign rd_sel    = sel_q;
endmodule

// File: rtl/sfsr_reg_bank.sv
module sfsr_reg_bank
  import sfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              wr_commit,
  input  logic [CNT_W-1:0]  wr_len,
  input  wr_buf_t           wr_bytes,
  input  logic              busy_in,
  input  logic              suspend_in,
  output logic [BYTE_W-1:0] stat1,
  output logic [BYTE_W-1:0] stat2,
  output logic [BYTE_W-1:0] stat3
);
  logic [5:0] prot_q;
  logic wel_q, cmp_q, qe_q, srp1_q;
  logic [3:0] lock_q;
  logic [BYTE_W-2:0] cfg_q;
  logic apply;
  logic unused_bits;

  assign apply = wr_commit && wel_q;
  assign unused_bits = ^{wr_bytes[0][1:0], wr_bytes[1][7], wr_bytes[2][7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= '0;
      wel_q  <= 1'b0;
      cmp_q  <= 1'b0;
      qe_q   <= 1'b0;
      srp1_q <= 1'b0;
      lock_q <= '0;
      cfg_q  <= CFG_RESET;
    end else begin
      if (wel_set) wel_q <= 1'b1;
      if (wel_clr) wel_q <= 1'b0;
      if (apply) begin
        wel_q  <= 1'b0;
        prot_q <= wr_bytes[0][7:2];
        if (wr_len == CNT_W'(1)) begin
          cmp_q  <= 1'b0;
          qe_q   <= 1'b0;
          srp1_q <= 1'b0;
        end else begin
          cmp_q  <= wr_bytes[1][6];
          qe_q   <= wr_bytes[1][1];
          srp1_q <= wr_bytes[1][0];
          lock_q <= lock_q | wr_bytes[1][5:2];
        end
        if (wr_len == WR_MAX) cfg_q <= wr_bytes[2][6:0];
      end
    end
  end

  assign stat1 = {prot_q, wel_q, busy_in};
  assign stat2 = {suspend_in, cmp_q, lock_q, qe_q, srp1_q};
  assign stat3 = {1'b0, cfg_q};
endmodule

// File: rtl/sfsr_status_regfile.sv
module sfsr_status_regfile
  import sfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              cs_done,
  input  logic              cs_ragged,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_byte,
  input  logic              busy_in,
  input  logic              suspend_in,
  output logic [BYTE_W-1:0] stat1,
  output logic [BYTE_W-1:0] stat2,
  output logic [BYTE_W-1:0] stat3
);
  logic rd_active, wel_set, wel_clr, wr_commit;
  logic [1:0] rd_sel;
  logic [CNT_W-1:0] wr_len;
  wr_buf_t wr_bytes;
  logic [NREG-1:0][BYTE_W-1:0] regs_view;

  assign cmd_ready = !rd_active || rsp_ready;

  sfsr_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .byte_fire(cmd_valid && cmd_ready), .byte_in(cmd_byte),
    .end_mark(cs_done), .end_ragged(cs_ragged),
    .rd_active(rd_active), .rd_sel(rd_sel),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_commit(wr_commit), .wr_len(wr_len), .wr_bytes(wr_bytes)
  );

  sfsr_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .wr_commit(wr_commit), .wr_len(wr_len), .wr_bytes(wr_bytes),
    .busy_in(busy_in), .suspend_in(suspend_in),
    .stat1(stat1), .stat2(stat2), .stat3(stat3)
  );

  assign regs_view = {stat3, stat2, stat1};
  assign rsp_valid = rd_active;
  assign rsp_byte  = regs_view[rd_sel];
endmodule

// File: rtl/sfsr_status_chk.sv
module sfsr_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_done,
  input logic       cs_ragged,
  input logic       commit,
  input logic       rsp_valid,
  input logic [7:0] stat1,
  input logic [7:0] stat2,
  input logic [7:0] stat3
);
  logic [21:0] held;
  assign held = {stat1[7:1], stat2[6:0], stat3};

  a_r10_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_done |=> $stable(held));
  a_r10_rsp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done |=> !rsp_valid);
  a_r9_partial_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_done && cs_ragged |=> $stable(held));
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat2[5:2]) & ~stat2[5:2]) == 4'b0));
  a_r8_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !stat1[1]);
  a_r4_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !stat1[1] |=> $stable(held));
endmodule

bind sfsr_status_regfile sfsr_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_done(cs_done), .cs_ragged(cs_ragged),
  .commit(wr_commit), .rsp_valid(rsp_valid),
  .stat1(stat1), .stat2(stat2), .stat3(stat3)
);

// File: tb/sfsr_status_regfile_test.sv
module sfsr_status_regfile_test;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cs_done = 0, cs_ragged = 0, rsp_ready = 1;
  logic busy_in = 0, suspend_in = 0;
  logic [7:0] cmd_byte = 0;
  logic cmd_ready, rsp_valid;
  logic [7:0] rsp_byte, stat1, stat2, stat3;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  byte unsigned q[$];
  logic [5:0] m_prot; logic m_wel, m_cmp, m_qe, m_srp1;
  logic [3:0] m_lock; logic [6:0] m_cfg;

  always #5 clk = ~clk;

  sfsr_status_regfile uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .cs_done(cs_done), .cs_ragged(cs_ragged),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_byte(rsp_byte),
    .busy_in(busy_in), .suspend_in(suspend_in),
    .stat1(stat1), .stat2(stat2), .stat3(stat3)
  );

  function automatic bit m_reading();
    return q.size() > 0 && (q[0] == 8'h05 || q[0] == 8'h35 || q[0] == 8'h33);
  endfunction
  function automatic logic [7:0] e1(); return {m_prot, m_wel, busy_in}; endfunction
  function automatic logic [7:0] e2(); return {suspend_in, m_cmp, m_lock, m_qe, m_srp1}; endfunction
  function automatic logic [7:0] e3(); return {1'b0, m_cfg}; endfunction
  function automatic logic [7:0] erd();
    if (q[0] == 8'h35) return e2();
    if (q[0] == 8'h33) return e3();
    return e1();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_prot = 0; m_wel = 0; m_cmp = 0; m_qe = 0; m_srp1 = 0; m_lock = 0; m_cfg = 7'h10;
    end else begin
      if (cmd_valid && (!m_reading() || rsp_ready)) q.push_back(cmd_byte);
      if (cs_done) begin
        if (!cs_ragged && q.size() > 0) begin
          case (q[0])
            8'h06: m_wel = 1;
            8'h04: m_wel = 0;
            8'h01: if (q.size() > 1 && m_wel) begin
              m_prot = q[1][7:2];
              if (q.size() == 2) begin m_cmp = 0; m_qe = 0; m_srp1 = 0; end
              else begin
                m_cmp = q[2][6]; m_qe = q[2][1]; m_srp1 = q[2][0];
                m_lock = m_lock | q[2][5:2];
              end
              if (q.size() >= 4) m_cfg = q[3][6:0];
              m_wel = 0;
            end
            default: ;
          endcase
        end
        q.delete();
      end
    end
  end

  task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", r, got, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " stat1"}, stat1, e1());
      chk({cur_req, " stat2"}, stat2, e2());
      chk({cur_req, " stat3"}, stat3, e3());
      chk({cur_req, " rsp_valid"}, {7'b0, rsp_valid}, {7'b0, m_reading()});
      chk({cur_req, " cmd_ready"}, {7'b0, cmd_ready}, {7'b0, !m_reading() || rsp_ready});
      if (m_reading()) chk({cur_req, " rsp_byte"}, rsp_byte, erd());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // drive one byte slot starting at a negedge
  task automatic put(input logic [7:0] b, input bit last);
    cmd_valid = 1; cmd_byte = b; cs_done = last; cs_ragged = 0;
    @(negedge clk);
    cmd_valid = 0; cs_done = 0;
  endtask
  task automatic ragged_end();
    cs_done = 1; cs_ragged = 1;
    @(negedge clk);
    cs_done = 0; cs_ragged = 0;
  endtask
  task automatic wen(); put(8'h06, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 stat1 reset", stat1, 8'h00);
    chk("R1 stat2 reset", stat2, 8'h00);
    chk("R1 stat3 reset", stat3, 8'h10);

    cur_req = "R2";
    put(8'h05, 0);
    chk("R2 rsp_valid in read", {7'b0, rsp_valid}, 8'h01);
    busy_in = 1;
    #1 chk("R11 busy mirror live", rsp_byte, 8'h01);
    put(8'hA5, 0);
    busy_in = 0;
    #1 chk("R2 repeated read live", rsp_byte, 8'h00);
    rsp_ready = 0;
    #1 chk("R2 cmd_ready follows rsp_ready", {7'b0, cmd_ready}, 8'h00);
    put(8'h11, 0);
    rsp_ready = 1;
    put(8'h22, 1);
    chk("R10 rsp drops after end", {7'b0, rsp_valid}, 8'h00);

    cur_req = "R4";
    put(8'h01, 0); put(8'hFC, 1);
    chk("R4 write without latch", stat1, 8'h00);

    cur_req = "R3";
    wen();
    chk("R3 write enable", stat1, 8'h02);
    put(8'h04, 1);
    chk("R3 write disable", stat1, 8'h00);

    cur_req = "R5";
    wen(); put(8'h01, 0); put(8'hFF, 1);
    chk("R5 one byte write masks bits 1:0", stat1, 8'hFC);
    chk("R8 latch cleared", {7'b0, stat1[1]}, 8'h00);

    cur_req = "R7";
    wen(); put(8'h01, 0); put(8'h00, 0); put(8'hFF, 1);
    chk("R7 second byte", stat2, 8'h7F);
    chk("R7 stat3 kept on two bytes", stat3, 8'h10);
    wen(); put(8'h01, 0); put(8'h00, 0); put(8'h00, 1);
    chk("R7 lock bits sticky", stat2, 8'h3C);

    cur_req = "R6";
    wen(); put(8'h01, 0); put(8'h00, 0); put(8'h43, 1);
    chk("R6 setup", stat2, 8'h7F);
    wen(); put(8'h01, 0); put(8'h08, 1);
    chk("R6 one byte clears cmp qe srp1", stat2, 8'h3C);
    chk("R6 stat1 loaded", stat1, 8'h08);

    cur_req = "R7";
    wen(); put(8'h01, 0); put(8'h04, 0); put(8'h40, 0); put(8'hFF, 0); put(8'h00, 1);
    chk("R7 third byte, fourth ignored", stat3, 8'h7F);
    chk("R7 cmp set", stat2, 8'h7C);

    cur_req = "R9";
    wen(); put(8'h01, 0); put(8'h00, 0); ragged_end();
    chk("R9 partial keeps stat1", stat1, 8'h06);
    put(8'h04, 0); ragged_end();
    chk("R9 partial keeps latch", {7'b0, stat1[1]}, 8'h01);
    put(8'h04, 1);

    cur_req = "R11";
    suspend_in = 1;
    put(8'h35, 0);
    #1 chk("R11 suspend in stat2 read", rsp_byte, 8'hFC);
    put(8'h00, 0);
    put(8'h33, 1);
    suspend_in = 0;
    put(8'h33, 0);
    #1 chk("R2 read stat3", rsp_byte, 8'h7F);
    put(8'h00, 1);
    cur_req = "R10";
    put(8'h9F, 0); put(8'h01, 0); put(8'h06, 1);
    chk("R10 unknown opcode ignored", stat1, 8'h04);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule